// File: doc/BRIEF.md
# High-Bandwidth OUT Transaction Splitter

This block breaks one micro-frame's worth of OUT data for a periodic endpoint into individual bus transactions. A request carries three values: the total byte count, the largest packet the endpoint accepts, and a transaction budget of one to three. The block then starts packets one at a time. Each packet is sized to the smaller of the packet limit and the bytes still left. After each start it waits for the transaction engine to report completion. A completion may carry an error code, and a nonzero code abandons the rest of the micro-frame.

When the sequence ends, the block raises a one-cycle completion pulse. With it come the remaining byte count to be written back to the descriptor, the error code, and a flag for a zero budget. A zero budget has no meaning for this transfer type. The block handles it as a defined no-op that issues nothing and raises the flag. Moving data, forming addresses, token and handshake signalling, and fetching descriptors are all handled elsewhere.

Top module: `hbOutSplitter`

## Requirements
- R1: A request with budget `reqMult` of 1, 2 or 3 produces at most that many `txStart` pulses before its `doneValid` pulse.
- R2: A request with `reqMult` equal to 0 produces no `txStart`. It yields `doneValid` in the cycle after acceptance, with `doneBadMult`=1, `doneErr`=0 and `doneRemain` equal to the requested length.
- R3: `txStart` lasts exactly one cycle. While it is high, `txBytes` equals the smaller of the captured packet limit and the remaining length.
- R4: Each completion whose `txErr` is 0 lowers the remaining length by the packet limit, saturating at zero. `doneRemain` reports the final remaining length.
- R5: Lengths are 12 bits wide and packet limits are 11 bits wide (up to 1024). A 3072-byte request with a 1024-byte limit and a budget of 3 gives three full packets and leaves 0 remaining.
- R6: `active` is high from the cycle after acceptance until the last completion is taken. It is low during the single-cycle `doneValid` pulse, and `reqReady` returns in the cycle after that pulse.
- R7: No further packet starts once the remaining length reaches zero, even if budget is left. A request of length 0 starts no packet and completes in the cycle after acceptance with `doneBadMult`=0.
- R8: A completion with nonzero `txErr` ends the sequence. `doneErr` carries that code, and the failing transaction does not lower the remaining length.
- R9: A request is taken only when `reqReady` is high. A `reqValid` raised while a sequence runs changes neither the current sequence nor its reported results.
- R10: `txDone` is ignored unless the block is waiting for a completion.
- R11: The first `txStart` comes in the cycle after acceptance. Each following `txStart` comes in the cycle after the completion that allowed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqLen | input | 12 | Total bytes for the micro-frame |
| reqMps | input | 11 | Largest packet size in bytes |
| reqMult | input | 2 | Transaction budget (0 is invalid) |
| reqReady | output | 1 | Idle and able to take a request |
| active | output | 1 | Sequence in progress |
| txStart | output | 1 | Start one bus transaction |
| txBytes | output | 11 | Byte count for the started transaction |
| txDone | input | 1 | Current transaction finished |
| txErr | input | 2 | Error code returned with txDone, 0 = success |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRemain | output | 12 | Remaining length for write-back |
| doneErr | output | 2 | Error code of the aborting transaction, or 0 |
| doneBadMult | output | 1 | Request had a zero budget |

## Verification
The bench builds the block with its default widths: a 12-bit length, an 11-bit packet limit, a 2-bit budget and a 2-bit error code. With these widths the full 3072-byte case fits, as do limits of 1 byte and 1024 bytes and every budget value including the invalid zero. Because the budget field is only two bits wide, every budget is exercised directly. Early termination on length, saturation of the remainder, abort at each position and long completion latencies can all be reached in a few hundred cycles.

// File: rtl/hbsPkg.sv
package hbsPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } hbsState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // account a finished transaction
  } hbsStrobe_t;

  // Conditions reported back by the datapath
  typedef struct packed {
    logic badReq;   // incoming request needs no transaction
    logic lastTxn;  // current transaction ends the sequence on success
  } hbsStatus_t;
endpackage

// File: rtl/hbsDatapath.sv
module hbsDatapath
  import hbsPkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int MPS_W  = 11,
  parameter int MULT_W = 2,
  parameter int ERR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbsStrobe_t        strobe,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [MPS_W-1:0]  reqMps,
  input  logic [MULT_W-1:0] reqMult,
  input  logic [ERR_W-1:0]  txErr,
  output hbsStatus_t        status,
  output logic [MPS_W-1:0]  txBytes,
  output logic [LEN_W-1:0]  doneRemain,
  output logic [ERR_W-1:0]  doneErr,
  output logic              doneBadMult
);
  localparam int EXT_PAD = LEN_W - MPS_W;

  logic [LEN_W-1:0]  remainQ;
  logic [MPS_W-1:0]  mpsQ;
  logic [MULT_W-1:0] multQ;
  logic [MULT_W-1:0] cntQ;
  logic [ERR_W-1:0]  errQ;
  logic              badQ;

  logic [LEN_W-1:0]  mpsExt;
  logic [LEN_W-1:0]  remainNext;
  logic [MULT_W-1:0] cntNext;
  logic              remainFits;

  assign mpsExt     = {{EXT_PAD{1'b0}}, mpsQ};
  assign remainFits = (remainQ <= mpsExt);
  assign remainNext = remainFits ? '0 : (remainQ - mpsExt);
  assign cntNext    = cntQ + MULT_W'(1);

  always_comb begin
    txBytes = remainFits ? remainQ[MPS_W-1:0] : mpsQ;
  end

  assign status.badReq  = (reqMult == '0) || (reqLen == '0);
  assign status.lastTxn = remainFits || (cntNext == multQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remainQ <= '0;
      mpsQ    <= '0;
      multQ   <= '0;
      cntQ    <= '0;
      errQ    <= '0;
      badQ    <= 1'b0;
    end else if (strobe.load) begin
      remainQ <= reqLen;
      mpsQ    <= reqMps;
      multQ   <= reqMult;
      cntQ    <= '0;
      errQ    <= '0;
      badQ    <= (reqMult == '0);
    end else if (strobe.step) begin
      cntQ <= cntNext;
      errQ <= txErr;
      if (txErr == '0) begin
        remainQ <= remainNext;
      end
    end
  end

  assign doneRemain  = remainQ;
  assign doneErr     = errQ;
  assign doneBadMult = badQ;
endmodule

// File: rtl/hbsControl.sv
module hbsControl
  import hbsPkg::*;
#(
  parameter int ERR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             txDone,
  input  logic [ERR_W-1:0] txErr,
  input  hbsStatus_t       status,
  output hbsStrobe_t       strobe,
  output logic             reqReady,
  output logic             active,
  output logic             txStart,
  output logic             doneValid
);
  hbsState_e stateQ, stateD;

  always_comb begin
    stateD       = stateQ;
    strobe       = '0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = status.badReq ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: begin
        if (txDone) begin
          strobe.step = 1'b1;
          stateD = ((txErr != '0) || status.lastTxn) ? ST_DONE : ST_ISSUE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady  = (stateQ == ST_IDLE);
  assign txStart   = (stateQ == ST_ISSUE);
  assign active    = (stateQ == ST_ISSUE) || (stateQ == ST_WAIT);
  assign doneValid = (stateQ == ST_DONE);
endmodule

// File: rtl/hbOutSplitter.sv
module hbOutSplitter
  import hbsPkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int MPS_W  = 11,
  parameter int MULT_W = 2,
  parameter int ERR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [MPS_W-1:0]  reqMps,
  input  logic [MULT_W-1:0] reqMult,
  output logic              reqReady,
  output logic              active,
  output logic              txStart,
  output logic [MPS_W-1:0]  txBytes,
  input  logic              txDone,
  input  logic [ERR_W-1:0]  txErr,
  output logic              doneValid,
  output logic [LEN_W-1:0]  doneRemain,
  output logic [ERR_W-1:0]  doneErr,
  output logic              doneBadMult
);
  hbsStrobe_t strobe;
  hbsStatus_t status;

  hbsControl #(.ERR_W(ERR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .txDone    (txDone),
    .txErr     (txErr),
    .status    (status),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .active    (active),
    .txStart   (txStart),
    .doneValid (doneValid)
  );

  hbsDatapath #(
    .LEN_W (LEN_W),
    .MPS_W (MPS_W),
    .MULT_W(MULT_W),
    .ERR_W (ERR_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqLen     (reqLen),
    .reqMps     (reqMps),
    .reqMult    (reqMult),
    .txErr      (txErr),
    .status     (status),
    .txBytes    (txBytes),
    .doneRemain (doneRemain),
    .doneErr    (doneErr),
    .doneBadMult(doneBadMult)
  );
endmodule

// File: rtl/hbsChecker.sv
module hbsChecker #(
  parameter int LEN_W  = 12,
  parameter int MPS_W  = 11,
  parameter int MULT_W = 2,
  parameter int ERR_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [LEN_W-1:0]  reqLen,
  input logic [MPS_W-1:0]  reqMps,
  input logic [MULT_W-1:0] reqMult,
  input logic              reqReady,
  input logic              active,
  input logic              txStart,
  input logic [MPS_W-1:0]  txBytes,
  input logic              txDone,
  input logic [ERR_W-1:0]  txErr,
  input logic              doneValid,
  input logic              doneBadMult,
  input logic [ERR_W-1:0]  doneErr
);
  logic              accept;
  logic [MPS_W-1:0]  capMps;
  logic [MULT_W-1:0] capMult;
  logic [MULT_W:0]   startCnt;

  assign accept = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capMps   <= '0;
      capMult  <= '0;
      startCnt <= '0;
    end else if (accept) begin
      capMps   <= reqMps;
      capMult  <= reqMult;
      startCnt <= '0;
    end else if (txStart) begin
      startCnt <= startCnt + 1'b1;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart); // R3

  AST_BYTES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txBytes <= capMps)); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (startCnt < {1'b0, capMult})); // R1

  AST_BAD_MULT: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMult == '0) |=> (doneValid && doneBadMult && !txStart)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (reqReady && !active && !doneValid)); // R6

  AST_FIRST_START: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqMult != '0 && reqLen != '0) |=> txStart); // R11

  AST_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (active && !txStart && txDone && txErr != '0) |=> (doneValid && doneErr == $past(txErr))); // R8
endmodule

bind hbOutSplitter hbsChecker #(
  .LEN_W (LEN_W),
  .MPS_W (MPS_W),
  .MULT_W(MULT_W),
  .ERR_W (ERR_W)
) i_hbsChecker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqLen     (reqLen),
  .reqMps     (reqMps),
  .reqMult    (reqMult),
  .reqReady   (reqReady),
  .active     (active),
  .txStart    (txStart),
  .txBytes    (txBytes),
  .txDone     (txDone),
  .txErr      (txErr),
  .doneValid  (doneValid),
  .doneBadMult(doneBadMult),
  .doneErr    (doneErr)
);

// File: tb/test_hbOutSplitter.sv
`timescale 1ns/1ps
module test_hbOutSplitter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] reqLen = '0;
  logic [10:0] reqMps = '0;
  logic [1:0]  reqMult = '0;
  logic        reqReady, active, txStart, doneValid, doneBadMult;
  logic [10:0] txBytes;
  logic        txDone = 1'b0;
  logic [1:0]  txErr = '0;
  logic [11:0] doneRemain;
  logic [1:0]  doneErr;

  always #5 clk = ~clk;

  hbOutSplitter i_hbOutSplitter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .reqMps(reqMps), .reqMult(reqMult), .reqReady(reqReady), .active(active),
    .txStart(txStart), .txBytes(txBytes), .txDone(txDone), .txErr(txErr),
    .doneValid(doneValid), .doneRemain(doneRemain), .doneErr(doneErr),
    .doneBadMult(doneBadMult)
  );

  int vecCnt = 0;
  int errCnt = 0;

  // Behavioural reference: phase 0 idle, 1 starting, 2 waiting, 3 reporting
  int mPhase = 0;
  int mRem = 0, mMps = 0, mMult = 0, mCnt = 0, mErr = 0;
  bit mBad = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mRem = 0; mMps = 0; mMult = 0; mCnt = 0; mErr = 0; mBad = 0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin           // R9 only idle accepts
          mRem = reqLen; mMps = reqMps; mMult = reqMult; mCnt = 0; mErr = 0;
          mBad = (reqMult == 0);
          mPhase = (reqMult == 0 || reqLen == 0) ? 3 : 1;   // R2 R7
        end
        1: mPhase = 2;
        2: if (txDone) begin             // R10 done honoured only here
          mCnt++;
          if (txErr != 0) begin mErr = txErr; mPhase = 3; end     // R8
          else begin
            mRem = (mRem > mMps) ? mRem - mMps : 0;              // R4
            mPhase = (mRem == 0 || mCnt == mMult) ? 3 : 1;       // R1 R7
          end
        end
        default: mPhase = 0;
      endcase
    end
  end

  task automatic chk(string req, string name, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int expBytes;
    chk("R9", "reqReady", reqReady, mPhase == 0);
    chk("R6", "active", active, mPhase == 1 || mPhase == 2);
    chk("R11", "txStart", txStart, mPhase == 1);
    chk("R6", "doneValid", doneValid, mPhase == 3);
    if (mPhase == 1) begin
      expBytes = (mRem < mMps) ? mRem : mMps;
      chk("R3", "txBytes", txBytes, expBytes);
    end
    if (mPhase == 3) begin
      chk("R4", "doneRemain", doneRemain, mRem);
      chk("R8", "doneErr", doneErr, mErr);
      chk("R2", "doneBadMult", doneBadMult, mBad);
    end
  endtask

  // Responder state
  int lat = 1;
  int waitCnt = 0;
  int txnIdx = 0;
  int errAt = -1;
  int errCode = 0;
  bit strayDone = 0;
  int startSeen = 0;

  task automatic tick();
    @(negedge clk);
    compareAll();
    if (txStart) startSeen++;
    reqValid = 1'b0;
    txDone = 1'b0;
    txErr = '0;
    if (waitCnt > 0) begin
      waitCnt--;
      if (waitCnt == 0) begin
        txDone = 1'b1;
        txErr = (txnIdx == errAt) ? 2'(errCode) : 2'd0;
        txnIdx++;
      end
    end
    if (txStart) waitCnt = lat;
    if (strayDone && mPhase == 0) begin   // R10 stray completion while idle
      txDone = 1'b1;
      txErr = 2'd3;
    end
  endtask

  task automatic runReq(int len, int mps, int mult, int eAt, int eCode, int l,
                        bit busyPoke, int expStarts, string tag);
    int guard;
    lat = l; errAt = eAt; errCode = eCode; txnIdx = 0; waitCnt = 0; startSeen = 0;
    tick();
    reqValid = 1'b1; reqLen = 12'(len); reqMps = 11'(mps); reqMult = 2'(mult);
    guard = 0;
    do begin
      tick();
      guard++;
      if (busyPoke && guard == 2) begin   // R9 request while busy
        reqValid = 1'b1; reqLen = 12'd7; reqMps = 11'd1; reqMult = 2'd0;
      end
    end while (mPhase != 0 && guard < 500);
    tick();
    vecCnt++;
    if (guard >= 500 || startSeen != expStarts) begin
      errCnt++;
      $display("FAIL %s start count actual=%0d expected=%0d", tag, startSeen, expStarts);
    end
  endtask

  initial begin
    #2_000_000;
    errCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (3) tick();            // reset state checked while rstN low
    rstN = 1'b1;
    tick();
    runReq(3072, 1024, 3, -1, 0, 1, 0, 3, "R5");     // full 3x1024
    runReq(2500, 1024, 3, -1, 0, 1, 0, 3, "R3");     // short last packet
    runReq(1000, 512, 3, -1, 0, 2, 0, 2, "R7");      // stops before budget
    runReq(3000, 512, 2, -1, 0, 1, 0, 2, "R4");      // leftover remainder
    runReq(3000, 512, 1, -1, 0, 3, 0, 1, "R1");      // single transaction
    runReq(400, 100, 0, -1, 0, 1, 0, 0, "R2");       // zero budget
    runReq(0, 100, 2, -1, 0, 1, 0, 0, "R7");         // zero length
    runReq(3072, 1024, 3, 1, 2, 1, 0, 2, "R8");      // abort on second
    runReq(900, 300, 3, 0, 1, 2, 0, 1, "R8");        // abort on first
    runReq(2048, 700, 3, -1, 0, 5, 1, 3, "R9");      // long latency, busy poke
    runReq(3, 1, 3, -1, 0, 1, 0, 3, "R11");          // 1-byte packets
    strayDone = 1;
    repeat (4) tick();                               // R10 idle completions
    runReq(1500, 1024, 2, -1, 0, 1, 0, 2, "R10");
    strayDone = 0;
    runReq(1024, 1024, 3, -1, 0, 1, 0, 1, "R7");     // exact fit
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule